// File: doc/BRIEF.md
# Interlaced HD Tri-Level Sync Timing Generator

This block paces a 1920-wide interlaced high-definition component video raster at a 74.25 MHz pixel clock. On every pixel clock it emits a two-bit level code that a downstream converter turns into an analog level: blank, sync below blank, sync above blank, or picture. It also gives the pixel fetch logic a picture enable, a field flag and a one-cycle strobe at the start of each picture line.

Each line opens with a three-level horizontal sync: blank, then a low pulse, then a high pulse, then a blank back interval. A picture line then has a blank porch and the visible pixels. A blank line is blank to its end. The vertical interval uses half-length lines. Their bodies are single segments that are either blank or sync-low. The two fields use different counts of top-blank lines and half-lines, and this gives the half-line offset between them.

The block is a segment sequencer. A horizontal stage walks through the segments of a line and loads each length from a small table. A vertical stage walks through the line groups of a field and moves on whenever the horizontal stage ends a line. A synchronous reset starts the raster at the first pixel of the first top-blank line of field 0.

Top module: `hdtl_timing`

## Requirements
- R1: While and right after the synchronous reset `rst_i`, the block is at the first pixel of the first top-blank line of field 0: `level_o` is 00, `field_o` is 0, and `video_en_o` and `line_start_o` are 0.
- R2: Every line and half-line starts with H_FRONT (44) pixels of code 00, then H_LOW (44) pixels of code 01, then H_HIGH (44) pixels of code 10, then H_BACK (88) pixels of code 00. Codes: 00 blank, 01 sync-low, 10 sync-high, 11 video.
- R3: After its horizontal sync, a picture line has H_PORCH (60) pixels of code 00 and then H_ACT (1920) pixels of code 11. `video_en_o` is high exactly on code 11 pixels.
- R4: After its horizontal sync, a blank line has H_PORCH+H_ACT (1980) pixels of code 00.
- R5: Each field has, in order, top-blank lines (TOP_LINES=14 in field 0, 15 in field 1), ACT_LINES (540) picture lines and BOT_LINES (2) blank lines.
- R6: The vertical interval uses half-lines. Each is the horizontal sync followed by one segment of H_TOTAL/2 − sync width (880) pixels. VS_SEGS (10) consecutive half-lines carry code 01 in that segment.
- R7: In field 0, one blank half-line comes before the sync-low half-lines and one comes after them. In field 1, none comes before and two come after.
- R8: `field_o` toggles only at the first pixel of a new field. Fields last (14+540+2) lines plus 12 half-lines in field 0, and (15+540+2) lines plus 12 half-lines in field 1.
- R9: `line_start_o` is a one-cycle pulse on the first pixel of each picture line, and only there.
- R10: A reset asserted at any point, including the first cycle of a field, restarts the raster as in R1. The sequence that follows is identical to the one after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| level_o | output | 2 | Level code for the current pixel |
| video_en_o | output | 1 | High on visible pixels |
| field_o | output | 1 | Current field parity |
| line_start_o | output | 1 | Strobe on the first pixel of each picture line |

## Verification
The sharpest coincidence is the last pixel of the last trailing half-line. In that cycle the vertical stage toggles the parity and reloads the top-blank group, and the length of that group depends on the new parity. A wrong ordering gives a field one line too long or too short. The bench runs several uninterrupted frames. It compares every pixel with a model indexed by field, line and column, and checks each field's cycle count, picture count and strobe count at every parity change. A second coincidence is a reset landing on the very first cycle of a field. The bench provokes it directly and judges it by the R1 state and by the pixel-exact restart that follows.

// File: rtl/hdtl_pkg.sv
package hdtl_pkg;

   typedef enum logic [1:0] {
      LV_BLANK   = 2'b00,
      LV_SYNC_LO = 2'b01,
      LV_SYNC_HI = 2'b10,
      LV_VIDEO   = 2'b11
   } level_e;

   // horizontal segments of one line
   typedef enum logic [2:0] {
      SG_FRONT,
      SG_LOW,
      SG_HIGH,
      SG_BACK,
      SG_PORCH,
      SG_PIXELS,
      SG_FILL,
      SG_HALF
   } seg_e;

   // line groups of one field
   typedef enum logic [2:0] {
      LK_TOP,
      LK_ACT,
      LK_BOT,
      LK_PRE,
      LK_VSYNC,
      LK_POST
   } lkind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic is_half(input lkind_e k);
      return (k == LK_PRE) || (k == LK_VSYNC) || (k == LK_POST);
   endfunction

endpackage

// File: rtl/hdtl_seg_rom.sv
module hdtl_seg_rom
   import hdtl_pkg::*;
#(
   parameter int H_FRONT = 44,
   parameter int H_LOW   = 44,
   parameter int H_HIGH  = 44,
   parameter int H_BACK  = 88,
   parameter int H_PORCH = 60,
   parameter int H_ACT   = 1920,
   parameter int H_HALF  = 880,
   parameter int CW      = 11
) (
   input  seg_e          seg_i,
   output logic [CW-1:0] len_m1_o
);

   always_comb begin
      case (seg_i)
         SG_FRONT:  len_m1_o = CW'(H_FRONT - 1);
         SG_LOW:    len_m1_o = CW'(H_LOW - 1);
         SG_HIGH:   len_m1_o = CW'(H_HIGH - 1);
         SG_BACK:   len_m1_o = CW'(H_BACK - 1);
         SG_PORCH:  len_m1_o = CW'(H_PORCH - 1);
         SG_PIXELS: len_m1_o = CW'(H_ACT - 1);
         SG_FILL:   len_m1_o = CW'(H_PORCH + H_ACT - 1);
         default:   len_m1_o = CW'(H_HALF - 1);
      endcase
   end

endmodule

// File: rtl/hdtl_hseq.sv
module hdtl_hseq
   import hdtl_pkg::*;
#(
   parameter int H_FRONT = 44,
   parameter int H_LOW   = 44,
   parameter int H_HIGH  = 44,
   parameter int H_BACK  = 88,
   parameter int H_PORCH = 60,
   parameter int H_ACT   = 1920,
   parameter int H_HALF  = 880,
   parameter int CW      = 11
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  lkind_e        kind_i,
   output seg_e          seg_o,
   output logic [CW-1:0] cnt_o,
   output logic          line_end_o
);

   seg_e          seg_q, seg_nx;
   logic [CW-1:0] cnt_q, nx_len;

   // segment order; the body after the back interval depends on the line group
   always_comb begin
      case (seg_q)
         SG_FRONT: seg_nx = SG_LOW;
         SG_LOW:   seg_nx = SG_HIGH;
         SG_HIGH:  seg_nx = SG_BACK;
         SG_BACK: begin
            if (kind_i == LK_ACT)      seg_nx = SG_PORCH;
            else if (is_half(kind_i))  seg_nx = SG_HALF;
            else                       seg_nx = SG_FILL;
         end
         SG_PORCH: seg_nx = SG_PIXELS;
         default:  seg_nx = SG_FRONT;
      endcase
   end

   hdtl_seg_rom #(
      .H_FRONT(H_FRONT), .H_LOW(H_LOW), .H_HIGH(H_HIGH), .H_BACK(H_BACK),
      .H_PORCH(H_PORCH), .H_ACT(H_ACT), .H_HALF(H_HALF), .CW(CW)
   ) u_next_len (
      .seg_i    (seg_nx),
      .len_m1_o (nx_len)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         seg_q <= SG_FRONT;
         cnt_q <= CW'(H_FRONT - 1);
      end else if (cnt_q == '0) begin
         seg_q <= seg_nx;
         cnt_q <= nx_len;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign seg_o      = seg_q;
   assign cnt_o      = cnt_q;
   assign line_end_o = (cnt_q == '0) &&
                       ((seg_q == SG_PIXELS) || (seg_q == SG_FILL) || (seg_q == SG_HALF));

endmodule

// File: rtl/hdtl_vseq.sv
module hdtl_vseq
   import hdtl_pkg::*;
#(
   parameter int TOP_LINES = 14,
   parameter int ACT_LINES = 540,
   parameter int BOT_LINES = 2,
   parameter int VS_SEGS   = 10,
   parameter int LW        = 10
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   line_end_i,
   output lkind_e kind_o,
   output logic   field_o
);

   lkind_e        kind_q, kind_nx;
   logic          field_q;
   logic [LW-1:0] cnt_q, lim;

   // last index of each group; field 1 has one more top line and one more trailing half-line
   always_comb begin
      case (kind_q)
         LK_TOP:   lim = LW'(TOP_LINES - 1) + LW'(field_q);
         LK_ACT:   lim = LW'(ACT_LINES - 1);
         LK_BOT:   lim = LW'(BOT_LINES - 1);
         LK_PRE:   lim = '0;
         LK_VSYNC: lim = LW'(VS_SEGS - 1);
         default:  lim = LW'(field_q);
      endcase
   end

   always_comb begin
      case (kind_q)
         LK_TOP:   kind_nx = LK_ACT;
         LK_ACT:   kind_nx = LK_BOT;
         LK_BOT:   kind_nx = field_q ? LK_VSYNC : LK_PRE;
         LK_PRE:   kind_nx = LK_VSYNC;
         LK_VSYNC: kind_nx = LK_POST;
         default:  kind_nx = LK_TOP;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         kind_q  <= LK_TOP;
         cnt_q   <= '0;
         field_q <= 1'b0;
      end else if (line_end_i) begin
         if (cnt_q == lim) begin
            kind_q <= kind_nx;
            cnt_q  <= '0;
            if (kind_q == LK_POST) field_q <= ~field_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign kind_o  = kind_q;
   assign field_o = field_q;

endmodule

// File: rtl/hdtl_timing.sv
module hdtl_timing
   import hdtl_pkg::*;
#(
   parameter int H_FRONT   = 44,
   parameter int H_LOW     = 44,
   parameter int H_HIGH    = 44,
   parameter int H_BACK    = 88,
   parameter int H_PORCH   = 60,
   parameter int H_ACT     = 1920,
   parameter int TOP_LINES = 14,
   parameter int ACT_LINES = 540,
   parameter int BOT_LINES = 2,
   parameter int VS_SEGS   = 10
) (
   input  logic       clk_i,
   input  logic       rst_i,
   output logic [1:0] level_o,
   output logic       video_en_o,
   output logic       field_o,
   output logic       line_start_o
);

   localparam int H_SYNC  = H_FRONT + H_LOW + H_HIGH + H_BACK;
   localparam int H_TOTAL = H_SYNC + H_PORCH + H_ACT;
   localparam int H_HALF  = H_TOTAL / 2 - H_SYNC;
   localparam int H_MAX   = max2(max2(max2(H_FRONT, H_LOW), max2(H_HIGH, H_BACK)),
                                 max2(H_PORCH + H_ACT, H_HALF));
   localparam int CW      = $clog2(H_MAX + 1);
   localparam int V_MAX   = max2(max2(TOP_LINES + 1, ACT_LINES), max2(BOT_LINES, VS_SEGS));
   localparam int LW      = $clog2(V_MAX + 1);

   // elaboration-time parameter checks
   if (H_FRONT < 1 || H_LOW < 1 || H_HIGH < 1 || H_BACK < 1 || H_PORCH < 1 || H_ACT < 1)
   begin : g_bad_hseg
      $error("every horizontal segment needs at least one pixel");
   end
   if (H_TOTAL % 2 != 0) begin : g_bad_total
      $error("line length must be even so that half-lines are exact");
   end
   if (H_HALF < 1) begin : g_bad_half
      $error("half-line body must be longer than zero");
   end
   if (TOP_LINES < 1 || ACT_LINES < 1 || BOT_LINES < 1 || VS_SEGS < 1) begin : g_bad_vert
      $error("every line group needs at least one line");
   end

   seg_e          seg;
   logic [CW-1:0] cnt;
   logic          line_end;
   lkind_e        kind;
   level_e        lvl;

   hdtl_hseq #(
      .H_FRONT(H_FRONT), .H_LOW(H_LOW), .H_HIGH(H_HIGH), .H_BACK(H_BACK),
      .H_PORCH(H_PORCH), .H_ACT(H_ACT), .H_HALF(H_HALF), .CW(CW)
   ) u_hseq (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .kind_i     (kind),
      .seg_o      (seg),
      .cnt_o      (cnt),
      .line_end_o (line_end)
   );

   hdtl_vseq #(
      .TOP_LINES(TOP_LINES), .ACT_LINES(ACT_LINES), .BOT_LINES(BOT_LINES),
      .VS_SEGS(VS_SEGS), .LW(LW)
   ) u_vseq (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .line_end_i (line_end),
      .kind_o     (kind),
      .field_o    (field_o)
   );

   always_comb begin
      case (seg)
         SG_LOW:    lvl = LV_SYNC_LO;
         SG_HIGH:   lvl = LV_SYNC_HI;
         SG_PIXELS: lvl = LV_VIDEO;
         SG_HALF:   lvl = (kind == LK_VSYNC) ? LV_SYNC_LO : LV_BLANK;
         default:   lvl = LV_BLANK;
      endcase
   end

   assign level_o      = lvl;
   assign video_en_o   = (seg == SG_PIXELS);
   assign line_start_o = (kind == LK_ACT) && (seg == SG_FRONT) && (cnt == CW'(H_FRONT - 1));

endmodule

// File: rtl/hdtl_timing_chk.sv
module hdtl_timing_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic [1:0] level_o,
   input logic       video_en_o,
   input logic       field_o,
   input logic       line_start_o
);

   logic [1:0] armed;

   always_ff @(posedge clk_i) begin
      if (rst_i)             armed <= 2'd0;
      else if (armed != 2'd2) armed <= armed + 2'd1;
   end

   // R2
   hi_after_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      (level_o == 2'b10) |-> ($past(level_o) == 2'b01 || $past(level_o) == 2'b10));

   // R6
   lo_after_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      (level_o == 2'b01 && $past(level_o) != 2'b01) |-> ($past(level_o) == 2'b00));

   // R3
   video_after_porch_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      $rose(video_en_o) |-> ($past(level_o) == 2'b00 && level_o == 2'b11));

   // R9
   strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      line_start_o |=> !line_start_o);

   // R9
   strobe_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      line_start_o |-> (level_o == 2'b00 && !video_en_o));

   // R8
   field_at_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i || armed != 2'd2)
      !$stable(field_o) |-> (level_o == 2'b00 && !line_start_o));

endmodule

bind hdtl_timing hdtl_timing_chk u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .level_o      (level_o),
   .video_en_o   (video_en_o),
   .field_o      (field_o),
   .line_start_o (line_start_o)
);

// File: tb/hdtl_timing_test.sv
module hdtl_timing_test;

   localparam int CLK_PERIOD = 10;
   localparam int FR = 3, LO = 4, HI = 5, BK = 6, PO = 7, AC = 21;
   localparam int TOPL = 3, ACTL = 4, BOTL = 2, VSN = 3;
   localparam int SYNCW = FR + LO + HI + BK;
   localparam int TOTW  = SYNCW + PO + AC;
   localparam int HALFW = TOTW / 2 - SYNCW;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] level;
   logic       video_en, field, line_start;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdtl_timing #(
      .H_FRONT(FR), .H_LOW(LO), .H_HIGH(HI), .H_BACK(BK), .H_PORCH(PO), .H_ACT(AC),
      .TOP_LINES(TOPL), .ACT_LINES(ACTL), .BOT_LINES(BOTL), .VS_SEGS(VSN)
   ) uut (
      .clk_i        (clk),
      .rst_i        (rst),
      .level_o      (level),
      .video_en_o   (video_en),
      .field_o      (field),
      .line_start_o (line_start)
   );

   // ---------------- reference model: field / line / column ----------------
   function automatic int top_of(int f);    return TOPL + f; endfunction
   function automatic int full_of(int f);   return top_of(f) + ACTL + BOTL; endfunction
   function automatic int pre_of(int f);    return (f == 0) ? 1 : 0; endfunction
   function automatic int lines_of(int f);  return full_of(f) + pre_of(f) + VSN + 1 + f; endfunction
   function automatic int len_of(int f, int ln);
      return (ln < full_of(f)) ? TOTW : SYNCW + HALFW;
   endfunction
   function automatic int cycles_of(int f);
      return full_of(f) * TOTW + (pre_of(f) + VSN + 1 + f) * (SYNCW + HALFW);
   endfunction
   function automatic bit is_act(int f, int ln);
      return (ln >= top_of(f)) && (ln < top_of(f) + ACTL);
   endfunction

   function automatic int exp_level(int f, int ln, int x);
      int h;
      if (x < FR)                 return 0;
      if (x < FR + LO)            return 1;
      if (x < FR + LO + HI)       return 2;
      if (x < SYNCW)              return 0;
      if (ln < full_of(f))        return (is_act(f, ln) && x >= SYNCW + PO) ? 3 : 0;
      h = ln - full_of(f);
      if (h < pre_of(f))          return 0;
      if (h < pre_of(f) + VSN)    return 1;
      return 0;
   endfunction

   function automatic string tag_of(int f, int ln, int x);
      int h;
      if (x < SYNCW)              return "R2";
      if (ln < full_of(f))        return is_act(f, ln) ? "R3" : "R4";
      h = ln - full_of(f);
      if (h >= pre_of(f) && h < pre_of(f) + VSN) return "R6";
      return "R7";
   endfunction

   int mf = 0, mln = 0, mx = 0;
   bit live = 1'b0;
   int rst_epoch = 0;

   always @(posedge clk) begin
      if (rst) begin
         mf <= 0; mln <= 0; mx <= 0; live <= 1'b1;
         rst_epoch <= rst_epoch + 1;
      end else if (live) begin
         if (mx == len_of(mf, mln) - 1) begin
            mx <= 0;
            if (mln == lines_of(mf) - 1) begin
               mln <= 0;
               mf  <= 1 - mf;
            end else begin
               mln <= mln + 1;
            end
         end else begin
            mx <= mx + 1;
         end
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s %s: got %0d expected %0d (field %0d line %0d col %0d)",
                  req, what, got, exp, mf, mln, mx);
      end
   endtask

   // per-pixel comparison and per-field totals, sampled at the falling edge
   int last_epoch = 0;
   bit fvalid = 1'b0;
   int fcyc = 0, fvid = 0, fls = 0;
   logic prev_field = 1'b0;

   always @(negedge clk) begin
      if (live && !done) begin
         check(tag_of(mf, mln, mx), "level", int'(level), exp_level(mf, mln, mx));
         check("R3", "video_en", int'(video_en), (exp_level(mf, mln, mx) == 3) ? 1 : 0);
         check("R8", "field", int'(field), mf);
         check("R9", "line_start", int'(line_start),
               (mx == 0 && is_act(mf, mln)) ? 1 : 0);
         if (rst_epoch != last_epoch) begin
            last_epoch = rst_epoch;
            fvalid = 1'b0;
            fcyc = 0; fvid = 0; fls = 0;
            prev_field = field;
         end else if (field != prev_field) begin
            if (fvalid) begin
               check("R8", "field cycles", fcyc, cycles_of(int'(prev_field)));
               check("R5", "picture pixels per field", fvid, ACTL * AC);
               check("R9", "strobes per field", fls, ACTL);
            end
            fvalid = 1'b1;
            fcyc = 0; fvid = 0; fls = 0;
            prev_field = field;
         end
         fcyc++;
         if (video_en)   fvid++;
         if (line_start) fls++;
      end
   end

   task automatic check_reset_state(input string req);
      check(req, "reset level", int'(level), 0);
      check(req, "reset field", int'(field), 0);
      check(req, "reset video_en", int'(video_en), 0);
      check(req, "reset line_start", int'(line_start), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      mismatched++;
      $display("FAIL watchdog: run did not complete (got timeout, expected completion)");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0c1d));
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1: state under reset
      check_reset_state("R1");
      rst = 1'b0;
      @(negedge clk);
      check("R1", "first pixel after reset level", int'(level), 0);

      // three uninterrupted frames: field lengths, parity, half-line layout
      repeat (3 * (cycles_of(0) + cycles_of(1))) @(negedge clk);

      // random reset points, R10
      for (int i = 0; i < 6; i++) begin
         repeat ($urandom_range(1200, 20)) @(negedge clk);
         rst = 1'b1;
         @(negedge clk);
         check_reset_state("R10");
         rst = 1'b0;
      end

      // directed: reset on the very first cycle of field 1 (R10)
      repeat (5) @(negedge clk);
      while (field !== 1'b1) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_reset_state("R10");
      rst = 1'b0;

      // directed: reset back-to-back, one cycle long, then a full frame (R1)
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "level one cycle after short reset", int'(level), 0);
      check("R1", "field one cycle after short reset", int'(field), 0);
      repeat (2 * (cycles_of(0) + cycles_of(1)) + 10) @(negedge clk);

      finish_run();
   end

endmodule